// File: doc/BRIEF.md
# Processor Interrupt Request Gating

This block turns eight level-sensitive interrupt lines from the rest of the chip into a single hard-interrupt request for a processor core. Each line is brought into the core clock domain through a two-flop synchronizer. The synchronized value becomes that line's pending bit in the cause vector. A pending bit stays set while its line is high and clears once the line falls. Lines are never latched.

The pending bits are combined with the per-line mask bits of the processor status word. The request can only be raised when interrupts are globally enabled and the core is outside exception level, error level and debug mode. The request is registered. Any change of a pending bit or of a status input is therefore reflected on the request one clock later. The status word and the debug flag are plain inputs here. Software writes to the status word, and the vectoring that follows a request, belong to other blocks.

Top module: `irq_gate_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge clears every pending bit and the request. Both read 0 after it, whatever the lines and status inputs are doing.
- R2: When line n rises, bit n of `cause_pending` reads 1 after the second rising clock edge that samples the line high. It still reads 0 after the first such edge.
- R3: When line n falls, bit n of `cause_pending` reads 0 after the second rising clock edge that samples it low. It still reads 1 after the first such edge.
- R4: `irq_req` can be 1 only if, at the previous edge, the global enable `st_int_en` was 1 and `st_exc_lvl`, `st_err_lvl` and `dbg_mode` were all 0.
- R5: When the global conditions are met, `irq_req` equals the OR over all n of (`st_irq_mask[n]` AND `cause_pending[n]`), one edge later.
- R6: If any global condition fails at an edge, `irq_req` is 0 after that edge, whatever the pending bits and the mask are.
- R7: A change of a status input alone moves `irq_req` after exactly one clock edge. A change of a line moves it after exactly three clock edges: two for the synchronizer and one for the request register.
- R8: Each line affects only its own pending bit, at bit position n for line n. Every pattern of the eight lines is reproduced bit-for-bit in `cause_pending`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_lines | input | 8 | External level-sensitive interrupt lines, asynchronous to `clk` |
| st_int_en | input | 1 | Status: global interrupt enable |
| st_exc_lvl | input | 1 | Status: exception level active |
| st_err_lvl | input | 1 | Status: error level active |
| st_irq_mask | input | 8 | Status: per-line interrupt mask, bit n enables line n |
| dbg_mode | input | 1 | Core is in debug mode |
| cause_pending | output | 8 | Pending bits, bit n mirrors synchronized line n |
| irq_req | output | 1 | Registered hard-interrupt request to the core |

## Verification
A broken synchronizer stage or a swapped pending bit shows at `cause_pending` two edges after the line moves. It appears as a bit in the wrong position or a value one edge early or late. The full sweep of all 256 line patterns against several masks exposes it at once. A wrong gating term or mask match shows on `irq_req` one edge after the status inputs settle. Walking all sixteen combinations of the four global conditions, and stepping from the open state into each closing condition, catches such a fault within one cycle.

// File: rtl/irq_gate_pkg.sv
// Package: shared widths and types for the interrupt request gating block.
// Assumes: the line count is fixed by the core's cause register layout.
package irq_gate_pkg;

    // Number of external interrupt lines and of synchronizer flops.
    localparam int IRQ_LINES   = 8;
    localparam int SYNC_DEPTH  = 2;

    // One bit per interrupt line.
    typedef logic [IRQ_LINES-1:0] irq_vec_t;

    // Global gating fields of the processor status word.
    typedef struct packed {
        logic int_en;
        logic exc_lvl;
        logic err_lvl;
        logic dbg;
    } irq_global_t;

    // True when every global condition allows a request.
    function automatic logic gate_open(input irq_global_t g);
        return g.int_en & ~g.exc_lvl & ~g.err_lvl & ~g.dbg;
    endfunction

endpackage

// File: rtl/irq_sync_bank.sv
// Module: irq_sync_bank
// Brings WIDTH asynchronous level signals into the clk domain through a
// chain of STAGES flops per bit. The last stage is the synchronized value.
// Assumes: inputs are levels held much longer than one clock period.
module irq_sync_bank #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            // First flop: samples the raw asynchronous lines.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[k] <= '0;
                else        stage_q[k] <= async_in;
            end
        end else begin : g_next
            // Later flops: pass the value one stage further.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[k] <= '0;
                else        stage_q[k] <= stage_q[k-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/irq_mask_match.sv
// Module: irq_mask_match
// Combinational per-line match of pending bits against mask bits, plus
// the OR reduction of all matches.
// Assumes: both vectors use the same bit-per-line numbering.
module irq_mask_match #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] pending,
    input  logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] match,
    output logic             any_match
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        assign match[i] = pending[i] & mask[i];
    end

    // Reduce the per-line matches to one flag.
    always_comb begin
        any_match = |match;
    end

endmodule

// File: rtl/irq_req_reg.sv
// Module: irq_req_reg
// Registers the hard-interrupt request from the global gate and the mask
// match. It is re-evaluated on every clock, so a change of any input shows
// on the request after one edge.
// Assumes: global fields are stable synchronous inputs.
module irq_req_reg
    import irq_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  irq_global_t glob,
    input  logic        any_match,
    output logic        req
);

    logic up_q;

    // Marks that at least one reset-free edge has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) up_q <= 1'b0;
        else        up_q <= 1'b1;
    end

    // Request register: open gate and at least one unmasked pending line.
    always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else        req <= gate_open(glob) & any_match;
    end

    AST_REQ_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && req) |-> $past(glob.int_en && !glob.exc_lvl && !glob.err_lvl && !glob.dbg)); // R4
    AST_REQ_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && req) |-> $past(any_match)); // R5
    AST_GATE_FAIL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob.int_en || glob.exc_lvl || glob.err_lvl || glob.dbg) |=> !req); // R6
    AST_MATCH_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (glob.int_en && !glob.exc_lvl && !glob.err_lvl && !glob.dbg && any_match) |=> req); // R7

endmodule

// File: rtl/irq_gate_top.sv
// Module: irq_gate_top
// Interrupt request gating: synchronizes eight interrupt lines into pending
// bits, matches them against the status mask and raises a registered
// request when the global status conditions allow it.
// Assumes: status inputs and debug flag are in the clk domain.
module irq_gate_top
    import irq_gate_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IRQ_LINES-1:0] irq_lines,
    input  logic                 st_int_en,
    input  logic                 st_exc_lvl,
    input  logic                 st_err_lvl,
    input  logic [IRQ_LINES-1:0] st_irq_mask,
    input  logic                 dbg_mode,
    output logic [IRQ_LINES-1:0] cause_pending,
    output logic                 irq_req
);

    irq_vec_t    pend;
    irq_vec_t    match;
    logic        any_match;
    irq_global_t glob;
    logic        seen_rst_q;
    logic [1:0]  run_cnt_q;

    assign glob = '{int_en: st_int_en, exc_lvl: st_exc_lvl,
                    err_lvl: st_err_lvl, dbg: dbg_mode};

    irq_sync_bank #(.WIDTH(IRQ_LINES), .STAGES(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_lines),
        .sync_out (pend)
    );

    irq_mask_match #(.WIDTH(IRQ_LINES)) u_match (
        .pending   (pend),
        .mask      (st_irq_mask),
        .match     (match),
        .any_match (any_match)
    );

    irq_req_reg u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .glob      (glob),
        .any_match (any_match),
        .req       (irq_req)
    );

    assign cause_pending = pend;

    // Records that a reset edge has been seen, for the reset check.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst_q <= 1'b1;
    end

    // Counts reset-free edges up to three, for the latency check.
    always_ff @(posedge clk) begin
        if (!rst_n)              run_cnt_q <= '0;
        else if (run_cnt_q != 3) run_cnt_q <= run_cnt_q + 2'd1;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        (seen_rst_q && !$past(rst_n)) |-> (cause_pending == '0 && !irq_req)); // R1

    if (SYNC_DEPTH == 2) begin : g_lat_chk
        AST_PENDING_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            (run_cnt_q >= 2) |-> (cause_pending == $past(irq_lines, 2))); // R2
    end

    AST_MATCH_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt_q >= 1) |-> ((match & ~cause_pending) == '0)); // R8

endmodule

// File: tb/tb_irq_gate_top.sv
// Bench for irq_gate_top: sweeps line patterns, masks and every global
// gating combination, with expected values computed from the requirements.
module tb_irq_gate_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] irq_lines;
    logic       st_int_en, st_exc_lvl, st_err_lvl, dbg_mode;
    logic [7:0] st_irq_mask;
    logic [7:0] cause_pending;
    logic       irq_req;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_gate_top dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_lines     (irq_lines),
        .st_int_en     (st_int_en),
        .st_exc_lvl    (st_exc_lvl),
        .st_err_lvl    (st_err_lvl),
        .st_irq_mask   (st_irq_mask),
        .dbg_mode      (dbg_mode),
        .cause_pending (cause_pending),
        .irq_req       (irq_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_glob(input logic [3:0] g);
        st_int_en  = g[0];
        st_exc_lvl = g[1];
        st_err_lvl = g[2];
        dbg_mode   = g[3];
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] masks [6];
        masks = '{8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h00};
        rst_n = 1'b0;
        irq_lines = 8'hFF;
        st_irq_mask = 8'hFF;
        set_glob(4'b0001);
        edges(3);
        // R1: reset clears pending and request despite active inputs
        chk(cause_pending == 8'h00, "R1 pending", cause_pending, 0);
        chk(irq_req == 1'b0, "R1 req", irq_req, 0);

        irq_lines = 8'h00;
        edges(1);
        rst_n = 1'b1;
        edges(3);

        // R2: rising line 5 appears after two edges, not one
        irq_lines = 8'h20;
        edges(1);
        chk(cause_pending == 8'h00, "R2 early", cause_pending, 8'h00);
        edges(1);
        chk(cause_pending == 8'h20, "R2 set", cause_pending, 8'h20);
        edges(2);
        // R3: falling line clears after two edges, not one
        irq_lines = 8'h00;
        edges(1);
        chk(cause_pending == 8'h20, "R3 early", cause_pending, 8'h20);
        edges(1);
        chk(cause_pending == 8'h00, "R3 clear", cause_pending, 8'h00);
        edges(2);

        // R8 / R5: every line pattern against several masks, gate open
        set_glob(4'b0001);
        for (int m = 0; m < 6; m++) begin
            st_irq_mask = masks[m];
            for (int v = 0; v < 256; v++) begin
                irq_lines = v[7:0];
                edges(3);
                chk(cause_pending == v[7:0], "R8 pattern", cause_pending, v);
                chk(irq_req == |(v[7:0] & masks[m]), "R5 match", irq_req,
                    int'(|(v[7:0] & masks[m])));
            end
        end

        // R4: all sixteen global combinations with a full match
        irq_lines = 8'hFF;
        st_irq_mask = 8'hFF;
        edges(3);
        for (int g = 0; g < 16; g++) begin
            set_glob(g[3:0]);
            edges(1);
            chk(irq_req == (g == 1), "R4 gate", irq_req, int'(g == 1));
        end

        // R6: from open state, each failing condition clears next edge
        for (int g = 2; g < 16; g++) begin
            set_glob(4'b0001);
            edges(1);
            chk(irq_req == 1'b1, "R6 open", irq_req, 1);
            set_glob(g[3:0]);
            edges(1);
            chk(irq_req == 1'b0, "R6 close", irq_req, 0);
        end

        // R7: status-only change moves the request after one edge
        set_glob(4'b0001);
        irq_lines = 8'h10;
        st_irq_mask = 8'h00;
        edges(3);
        chk(irq_req == 1'b0, "R7 before", irq_req, 0);
        st_irq_mask = 8'h10;
        edges(1);
        chk(irq_req == 1'b1, "R7 mask", irq_req, 1);

        // R7: line change moves the request after three edges
        st_irq_mask = 8'hFF;
        irq_lines = 8'h00;
        edges(3);
        chk(irq_req == 1'b0, "R7 idle", irq_req, 0);
        irq_lines = 8'h02;
        edges(2);
        chk(irq_req == 1'b0, "R7 early", irq_req, 0);
        edges(1);
        chk(irq_req == 1'b1, "R7 line", irq_req, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule